// File: doc/BRIEF.md
# Sleep-Mode Dual-Source Wake Detector

This block watches for wake-up requests while a single-wire bus transceiver sits in its low-power Sleep state. It accepts two sources. The first is the bus itself: a recessive-to-dominant change that stays dominant for a filter window of `BUS_CYC` clock cycles. The second is a switch-driven wake pin with no fixed active polarity. Its level is stored as a reference when Sleep is armed, and any level opposite to that reference that holds for `PIN_CYC` cycles counts as a wake. Both a closing and an opening switch can therefore wake the node.

Both raw inputs arrive as asynchronous logic levels. Each passes through a two-flop synchronizer before its qualification counter. A qualification counter reloads whenever its condition drops. On success the block emits a one-cycle `wake_o` pulse together with a source tag. After that it stays silent until Sleep is armed again. Leaving Sleep disarms the block and clears both counters.

Top module: `sleep_wake_detector`

## Requirements
- R1: Out of reset, `wake_o` is 0 and `wake_src_o` is 0 (the bus tag).
- R2: Armed with the pin reference at 0, a pin level of 1 that holds for `PIN_CYC` cycles gives exactly one `wake_o` pulse of one cycle, `PIN_CYC`+2 clocks after the first edge that samples the new raw level, with `wake_src_o` = 1 (pin tag).
- R3: Armed with the pin reference at 1, a pin level of 0 that holds for `PIN_CYC` cycles wakes the same way with `wake_src_o` = 1.
- R4: A pin excursion from the reference that lasts fewer than `PIN_CYC` cycles produces no pulse, and the count restarts from zero on the next excursion.
- R5: After the bus has been seen recessive (`bus_lvl_i` = 1) since arming, a dominant level (`bus_lvl_i` = 0) that holds for `BUS_CYC` cycles gives one pulse `BUS_CYC`+2 clocks after the first sampling edge, with `wake_src_o` = 0.
- R6: A dominant bus excursion shorter than `BUS_CYC` cycles produces no pulse.
- R7: If the bus is already dominant when Sleep is armed, that level never qualifies. A bus wake needs a recessive level after arming and then a full dominant window.
- R8: No pulse is produced while `sleep_i` is 0, or while the block is not armed. Dropping `sleep_i` disarms the block and clears both counters, so a new `arm_i` pulse is needed.
- R9: After a pulse, further qualifying input produces no pulse until `arm_i` re-arms the block.
- R10: If both sources qualify in the same cycle, a single pulse is emitted tagged as bus (`wake_src_o` = 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sleep_i | input | 1 | 1 while the transceiver is in Sleep |
| arm_i | input | 1 | One-cycle pulse at Sleep entry; captures the pin reference |
| bus_lvl_i | input | 1 | Raw bus level, 1 recessive, 0 dominant |
| wake_pin_i | input | 1 | Raw wake-switch level |
| wake_o | output | 1 | One-cycle wake pulse |
| wake_src_o | output | 1 | Source of the last pulse: 0 bus, 1 pin |

## Verification
On every cycle the assertions check the following:
- the pulse lasts one cycle;
- no pulse follows a cycle with `sleep_i` low or a fired detector;
- a pin-tagged pulse only follows a pin level opposite to the reference;
- a joint qualification yields the bus tag;
- a counter returns to zero whenever its condition drops.

The exact wake latency, the rejection of short excursions of random length, and the two pin polarities can only be shown by the bench's scenarios. The same holds for the need to see a recessive bus after arming and the re-arm sequence.

// File: rtl/swd_pkg.sv
package swd_pkg;

    typedef enum logic {
        SRC_BUS = 1'b0,
        SRC_PIN = 1'b1
    } wake_src_e;

    typedef struct packed {
        logic      pin_ref;
        logic      armed;
        logic      fired;
        logic      rec_seen;
        logic      wake;
        wake_src_e src;
    } det_state_t;

endpackage

// File: rtl/swd_sync2.sv
module swd_sync2 #(
    parameter int unsigned       W       = 1,
    parameter logic [W-1:0]      RST_VAL = '0
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [W-1:0] raw_i,
    output logic [W-1:0] sync_o
);
    logic [W-1:0] s1_d, s1_q, s2_d, s2_q;

    always_comb begin
        s1_d = raw_i;
        s2_d = s1_q;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            s1_q <= RST_VAL;
            s2_q <= RST_VAL;
        end else begin
            s1_q <= s1_d;
            s2_q <= s2_d;
        end
    end

    assign sync_o = s2_q;
endmodule

// File: rtl/swd_qual_filter.sv
module swd_qual_filter #(
    parameter int unsigned CYC = 16
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic clr_i,
    input  logic cond_i,
    output logic hit_o
);
    localparam int unsigned CW  = (CYC < 2) ? 1 : $clog2(CYC);
    localparam logic [CW-1:0] TOP = CW'(CYC - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr_i || !cond_i) begin
            cnt_d = '0;
        end else if (cnt_q != TOP) begin
            cnt_d = cnt_q + CW'(1);
        end
        hit_o = cond_i && !clr_i && (cnt_q == TOP);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cnt_q <= '0;
        else         cnt_q <= cnt_d;
    end

    // R4 / R8: a dropped condition or a clear always reloads the counter
    a_r4_reload: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!cond_i || clr_i) |=> (cnt_q == '0));
endmodule

// File: rtl/sleep_wake_detector.sv
module sleep_wake_detector
    import swd_pkg::*;
#(
    parameter int unsigned BUS_CYC = 16,
    parameter int unsigned PIN_CYC = 12
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic sleep_i,
    input  logic arm_i,
    input  logic bus_lvl_i,
    input  logic wake_pin_i,
    output logic wake_o,
    output logic wake_src_o
);
    localparam int unsigned NSRC = 2;
    localparam int unsigned IDX_BUS = 0;
    localparam int unsigned IDX_PIN = 1;

    logic [NSRC-1:0] raw, synced;
    logic            bus_s, pin_s;
    logic            active, flt_clr;
    logic            bus_cond, pin_cond, bus_hit, pin_hit;
    det_state_t      st_d, st_q;

    assign raw[IDX_BUS] = bus_lvl_i;
    assign raw[IDX_PIN] = wake_pin_i;

    swd_sync2 #(.W(NSRC), .RST_VAL(2'b01)) u_sync (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .raw_i (raw),
        .sync_o(synced)
    );

    assign bus_s = synced[IDX_BUS];
    assign pin_s = synced[IDX_PIN];

    always_comb begin
        active   = sleep_i && st_q.armed && !st_q.fired && !arm_i;
        flt_clr  = !sleep_i || arm_i;
        bus_cond = active && st_q.rec_seen && !bus_s;
        pin_cond = active && (pin_s != st_q.pin_ref);
    end

    swd_qual_filter #(.CYC(BUS_CYC)) u_bus_flt (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .clr_i (flt_clr),
        .cond_i(bus_cond),
        .hit_o (bus_hit)
    );

    swd_qual_filter #(.CYC(PIN_CYC)) u_pin_flt (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .clr_i (flt_clr),
        .cond_i(pin_cond),
        .hit_o (pin_hit)
    );

    always_comb begin
        st_d      = st_q;
        st_d.wake = 1'b0;
        if (!sleep_i) begin
            st_d.armed    = 1'b0;
            st_d.fired    = 1'b0;
            st_d.rec_seen = 1'b0;
        end else if (arm_i) begin
            st_d.armed    = 1'b1;
            st_d.fired    = 1'b0;
            st_d.rec_seen = 1'b0;
            st_d.pin_ref  = pin_s;
        end else begin
            if (active && bus_s) st_d.rec_seen = 1'b1;
            if (bus_hit || pin_hit) begin
                st_d.wake  = 1'b1;
                st_d.fired = 1'b1;
                st_d.src   = bus_hit ? SRC_BUS : SRC_PIN;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '{pin_ref: 1'b0, armed: 1'b0, fired: 1'b0,
                      rec_seen: 1'b0, wake: 1'b0, src: SRC_BUS};
        end else begin
            st_q <= st_d;
        end
    end

    assign wake_o     = st_q.wake;
    assign wake_src_o = st_q.src;

    // R9: the pulse lasts exactly one cycle
    a_r9_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wake_o |=> !wake_o);
    // R9: once fired, nothing fires until re-armed
    a_r9_fired_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.fired && !arm_i) |=> !wake_o);
    // R8: no pulse follows a cycle outside Sleep
    a_r8_sleep_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !sleep_i |=> !wake_o);
    // R10: joint qualification gives the bus tag
    a_r10_bus_priority: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (bus_hit && pin_hit) |=> (wake_o && wake_src_o == SRC_BUS));
    // R2 / R3: a pin-tagged pulse follows a level opposite to the reference
    a_r2_pin_opposes_ref: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wake_o && wake_src_o == SRC_PIN) |-> $past(pin_s != st_q.pin_ref));
    // R5: a bus-tagged pulse follows a dominant synchronized bus
    a_r5_bus_dominant: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wake_o && wake_src_o == SRC_BUS) |-> $past(!bus_s));
endmodule

// File: tb/tb_sleep_wake_detector.sv
module tb_sleep_wake_detector;
    localparam int BUS_CYC = 16;
    localparam int PIN_CYC = 12;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sleep = 1'b0, arm = 1'b0, bus = 1'b1, pin = 1'b0;
    logic wake, src;
    int   n_chk = 0, n_err = 0;
    bit   done = 0;

    always #4 clk = ~clk;

    sleep_wake_detector #(.BUS_CYC(BUS_CYC), .PIN_CYC(PIN_CYC)) dut (
        .clk_i(clk), .rst_ni(rst_n), .sleep_i(sleep), .arm_i(arm),
        .bus_lvl_i(bus), .wake_pin_i(pin), .wake_o(wake), .wake_src_o(src)
    );

    // quiet clocks before a pulse: one per qualifying cycle plus synchronizer slack
    function automatic int quiet_steps(int filt);
        return filt + 1;
    endfunction

    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic check(bit ok, string req, string what, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic quiet(int n, string req);
        for (int i = 0; i < n; i++) begin
            step();
            check(wake == 1'b0, req, "wake during quiet window", wake, 0);
        end
    endtask

    task automatic expect_wake(int filt, bit exp_src, string req);
        quiet(quiet_steps(filt), req);
        step();
        check(wake == 1'b1, req, "wake pulse", wake, 1);
        check(src == exp_src, req, "source tag", src, exp_src);
        step();
        check(wake == 1'b0, req, "pulse width", wake, 0);
    endtask

    task automatic go_sleep(bit ref_lvl, bit bus_lvl);
        sleep = 1'b0;
        step(); step();
        pin = ref_lvl; bus = bus_lvl; sleep = 1'b1;
        repeat (4) step();
        arm = 1'b1;
        step();
        arm = 1'b0;
    endtask

    initial begin
        int seed_v;
        bit r;
        seed_v = $urandom(32'd2024);
        step();
        // R1: reset state
        check(wake == 1'b0, "R1", "wake in reset", wake, 0);
        check(src == 1'b0, "R1", "src in reset", src, 0);
        rst_n = 1'b1;
        step();
        check(wake == 1'b0, "R1", "wake after reset", wake, 0);

        // R2: low-to-high pin wake
        go_sleep(1'b0, 1'b1);
        pin = 1'b1;
        expect_wake(PIN_CYC, 1'b1, "R2");

        // R3: high-to-low pin wake
        go_sleep(1'b1, 1'b1);
        pin = 1'b0;
        expect_wake(PIN_CYC, 1'b1, "R3");

        // R4: random short pin excursions, then a full one
        r = 1'($urandom_range(0, 1));
        go_sleep(r, 1'b1);
        for (int k = 0; k < 8; k++) begin
            int len;
            len = $urandom_range(1, PIN_CYC - 1);
            pin = ~r;
            quiet(len, "R4");
            pin = r;
            quiet(PIN_CYC + 3, "R4");
        end
        pin = ~r;
        expect_wake(PIN_CYC, 1'b1, "R4");

        // R5: bus dominant wake
        go_sleep(1'b0, 1'b1);
        bus = 1'b0;
        expect_wake(BUS_CYC, 1'b0, "R5");

        // R6: random short bus dominants
        go_sleep(1'b0, 1'b1);
        for (int k = 0; k < 8; k++) begin
            bus = 1'b0;
            quiet($urandom_range(1, BUS_CYC - 1), "R6");
            bus = 1'b1;
            quiet(4, "R6");
        end
        quiet(BUS_CYC + 3, "R6");

        // R7: bus already dominant at arming
        go_sleep(1'b0, 1'b0);
        quiet(BUS_CYC + 8, "R7");
        bus = 1'b1;
        quiet(4, "R7");
        bus = 1'b0;
        expect_wake(BUS_CYC, 1'b0, "R7");

        // R8: outside Sleep and without arming, no pulse
        go_sleep(1'b0, 1'b1);
        sleep = 1'b0;
        pin = 1'b1;
        quiet(PIN_CYC + 6, "R8");
        sleep = 1'b1;
        quiet(PIN_CYC + 6, "R8");

        // R10: both qualify together, bus tag wins
        go_sleep(1'b0, 1'b1);
        bus = 1'b0;
        quiet(BUS_CYC - PIN_CYC, "R10");
        pin = 1'b1;
        expect_wake(PIN_CYC, 1'b0, "R10");
        // R9: no further pulse until re-armed
        pin = 1'b0;
        quiet(6, "R9");
        pin = 1'b1;
        quiet(PIN_CYC + 10, "R9");
        go_sleep(1'b1, 1'b1);
        pin = 1'b0;
        expect_wake(PIN_CYC, 1'b1, "R9");

        // random source trials
        for (int k = 0; k < 8; k++) begin
            bit use_pin;
            r = 1'($urandom_range(0, 1));
            use_pin = 1'($urandom_range(0, 1));
            go_sleep(r, 1'b1);
            if (use_pin) begin
                pin = ~r;
                expect_wake(PIN_CYC, 1'b1, "R2");
            end else begin
                bus = 1'b0;
                expect_wake(BUS_CYC, 1'b0, "R5");
            end
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end
endmodule